// File: doc/BRIEF.md
# Timed Pulse Transmitter with Carrier Modulation

This block turns a queue of software-written symbols into a pulse train on one output pin. Each queued symbol is one level bit and a 16-bit length. The length is scaled by sixteen: it is placed above four zero bits in a 20-bit down-counter. That counter steps once per transmit clock enable, so one length unit lasts sixteen enables. When a symbol runs out, the next queued symbol follows with no gap. When the queue is empty and the last symbol has finished, the pin goes LOW and the transmitter reports idle.

When modulation is on, a HIGH symbol is not sent as a steady level. It is sent as a carrier whose period is sixteen enables. The HIGH part of each period lasts a number of sixteenths set by a 4-bit duty input. A LOW symbol is sent as silence. The block has a 16-entry symbol queue and a busy flag. It also has one interrupt, which reports either that the queue is at most half full or that the transmitter is idle. The enable pulse is generated outside the block.

Top module: `pulse_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared after that edge: `tx_out`, `busy`, `irq`, `fifo_full` and `fifo_count`.
- R2: A symbol is queued when `wr_valid` is high and the queue holds fewer than 16 entries. A write while `fifo_full` is high is dropped, even if a symbol is taken out in that same cycle. `fifo_count` is the number of queued symbols and never exceeds 16.
- R3: The symbol encoding is `wr_data[16]` = level and `wr_data[15:0]` = length N. A symbol with N>0 occupies exactly 16·N active ticks. A symbol with N=0 occupies one active tick. An active tick is a clock with `tick` and `tx_en` both high. `tx_out` follows the internal state with one clock of register delay.
- R4: While `tx_en` is low, the symbol counter, the carrier phase and the symbol position do not change.
- R5: The next queued symbol is taken on the active tick that ends the current symbol, so consecutive symbols leave no gap. If the transmitter is idle, a symbol is taken on the next active tick.
- R6: On the active tick that ends a symbol while the queue is empty, `busy` falls and `tx_out` goes LOW. `busy` stays low, and `tx_out` stays LOW, until a new symbol is taken.
- R7: With `mod_en` high, a HIGH symbol becomes a carrier with a period of 16 active ticks. In each period the carrier is HIGH for the first d+1 ticks, where d is `duty`. The carrier phase restarts at the first tick of each symbol. A LOW symbol gives a constant LOW. With `mod_en` low, a HIGH symbol gives a constant HIGH.
- R8: The setting `duty`=15 behaves exactly like `duty`=14, that is, HIGH for 15 of every 16 ticks.
- R9: `irq` is registered. With `irq_sel`=0 it shows that `fifo_count` was at most 8 in the previous cycle. With `irq_sel`=1 it shows that in the previous cycle `busy` was low or `tx_en` was low.
- R10: `busy` rises only when a symbol is taken from a non-empty queue. It stays high through back-to-back symbols and falls only at the end condition of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Transmit clock enable, one pulse per transmit clock |
| tx_en | input | 1 | Transmission enable; low freezes symbol timing |
| mod_en | input | 1 | Replace HIGH symbols by a carrier |
| duty | input | 4 | Carrier HIGH time in sixteenths minus one (15 acts as 14) |
| irq_sel | input | 1 | Interrupt source: 0 = queue at most half full, 1 = idle |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 17 | Bit 16 level, bits 15:0 length in units of 16 ticks |
| fifo_full | output | 1 | Queue holds 16 symbols |
| fifo_count | output | 5 | Number of queued symbols |
| busy | output | 1 | A symbol is being sent |
| tx_out | output | 1 | Registered pulse train output |
| irq | output | 1 | Registered transmit interrupt |

## Verification
Two events can fall in the same clock. The first pair is a queue write and the fetch of the next symbol; the full-queue case is the sharp one, because the write must be dropped although the fetch frees a slot. The second pair is the end of the last symbol and a write into the empty queue. In that case the transmitter must first go idle and then restart on the next active tick. Random write strobes at a high rate, combined with short lengths and dense ticks, make both pairs happen often. An independent cycle model of queue contents, remaining ticks and elapsed ticks judges `fifo_count`, `busy`, `tx_out` and `irq` on every clock.

// File: rtl/pulse_tx_pkg.sv
package pulse_tx_pkg;
  // Default sizes shared by all transmitter modules
  localparam int unsigned DUR_W   = 16;  // symbol length field
  localparam int unsigned SCALE_W = 4;   // length scaled by 2**SCALE_W ticks
  localparam int unsigned DEPTH   = 16;  // queue entries

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } tx_sym_t;
endpackage

// File: rtl/pulse_tx_fifo.sv
module pulse_tx_fifo #(
  parameter int unsigned WIDTH = 17,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so the array maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pulse_tx_seq.sv
module pulse_tx_seq #(
  parameter int unsigned DUR_W   = 16,
  parameter int unsigned SCALE_W = 4,
  localparam int unsigned CNT_W  = DUR_W + SCALE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             avail,
  input  logic             sym_lvl,
  input  logic [DUR_W-1:0] sym_dur,
  output logic             take,
  output logic             lvl,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  // Fetch on the tick that would drain the counter: 16*N ticks per symbol
  assign last = (cnt <= CNT_W'(1));
  assign take = act && last && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lvl  <= 1'b0;
      busy <= 1'b0;
    end else if (act) begin
      if (last) begin
        if (avail) begin
          cnt  <= {sym_dur, {SCALE_W{1'b0}}};
          lvl  <= sym_lvl;
          busy <= 1'b1;
        end else begin
          cnt  <= '0;
          lvl  <= 1'b0;
          busy <= 1'b0;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pulse_tx_carrier.sv
module pulse_tx_carrier #(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act,
  input  logic            restart,
  input  logic [PH_W-1:0] duty,
  output logic            hi
);
  localparam logic [PH_W-1:0] TOP = {PH_W{1'b1}};

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] eff;

  // The all-ones setting is reserved and folds onto the one below it
  assign eff = (duty == TOP) ? TOP - PH_W'(1) : duty;
  assign hi  = (phase <= eff);

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (restart) phase <= '0;
    else if (act)     phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/pulse_tx.sv
module pulse_tx
  import pulse_tx_pkg::*;
#(
  parameter int unsigned P_DUR_W   = DUR_W,
  parameter int unsigned P_SCALE_W = SCALE_W,
  parameter int unsigned P_DEPTH   = DEPTH,
  parameter bit          HAS_CARRIER = 1'b1,
  localparam int unsigned SYM_W = P_DUR_W + 1,
  localparam int unsigned CW    = $clog2(P_DEPTH + 1),
  localparam int unsigned HALF  = P_DEPTH / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 tx_en,
  input  logic                 mod_en,
  input  logic [P_SCALE_W-1:0] duty,
  input  logic                 irq_sel,
  input  logic                 wr_valid,
  input  logic [SYM_W-1:0]     wr_data,
  output logic                 fifo_full,
  output logic [CW-1:0]        fifo_count,
  output logic                 busy,
  output logic                 tx_out,
  output logic                 irq
);
  logic             act;
  logic [SYM_W-1:0] head;
  logic             q_empty;
  logic             seq_take;
  logic             seq_lvl;
  logic             car_hi;

  assign act = tick && tx_en;

  pulse_tx_fifo #(.WIDTH(SYM_W), .DEPTH(P_DEPTH)) i_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_valid),
    .wdata (wr_data),
    .pop   (seq_take),
    .rdata (head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (q_empty)
  );

  pulse_tx_seq #(.DUR_W(P_DUR_W), .SCALE_W(P_SCALE_W)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .avail   (!q_empty),
    .sym_lvl (head[SYM_W-1]),
    .sym_dur (head[P_DUR_W-1:0]),
    .take    (seq_take),
    .lvl     (seq_lvl),
    .busy    (busy)
  );

  generate
    if (HAS_CARRIER) begin : g_carrier
      pulse_tx_carrier #(.PH_W(P_SCALE_W)) i_car (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .restart (seq_take),
        .duty    (duty),
        .hi      (car_hi)
      );
    end else begin : g_plain
      assign car_hi = 1'b1;
    end
  endgenerate

  // Registered pin and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tx_out <= seq_lvl && (!mod_en || car_hi);
      irq    <= irq_sel ? (!busy || !tx_en) : (fifo_count <= CW'(HALF));
    end
  end
endmodule

// File: rtl/pulse_tx_chk.sv
module pulse_tx_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic          take,
  input logic          busy,
  input logic          tx_out
);
  // R2: a write into a full queue leaves the count unchanged when nothing leaves
  assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && wr_valid && !take) |=> (fifo_count == $past(fifo_count)));

  // R2: occupancy bound
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  // R6: an idle transmitter drives LOW on the next cycle
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tx_out);

  // R10: busy starts only from a non-empty queue
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(fifo_count) != '0));

  // R10: busy ends only when the queue was empty
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(fifo_count) == '0));
endmodule

bind pulse_tx pulse_tx_chk #(.DEPTH(P_DEPTH)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .fifo_full  (fifo_full),
  .fifo_count (fifo_count),
  .take       (seq_take),
  .busy       (busy),
  .tx_out     (tx_out)
);

// File: tb/test_pulse_tx.sv
module test_pulse_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, tx_en = 1'b0, mod_en = 1'b0, irq_sel = 1'b0;
  logic [3:0]  duty = 4'd7;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_data = '0;
  logic        fifo_full, busy, tx_out, irq;
  logic [4:0]  fifo_count;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  pulse_tx i_pulse_tx (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en), .mod_en(mod_en),
    .duty(duty), .irq_sel(irq_sel), .wr_valid(wr_valid), .wr_data(wr_data),
    .fifo_full(fifo_full), .fifo_count(fifo_count), .busy(busy),
    .tx_out(tx_out), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  // Reference model: queue contents, ticks left in symbol, ticks elapsed in symbol
  logic [16:0] q[$];
  int rem = 0, el = 0;
  bit m_lvl = 0, m_busy = 0, e_out = 0, e_irq = 0;

  function automatic bit carrier_on(input int elapsed, input int d);
    int eff;
    eff = (d == 15) ? 14 : d;
    return (elapsed % 16) < (eff + 1);
  endfunction

  always @(posedge clk) begin
    int sz;
    logic [16:0] ent;
    if (rst) begin
      q.delete(); rem = 0; el = 0; m_lvl = 0; m_busy = 0; e_out = 0; e_irq = 0;
    end else begin
      sz = q.size();
      e_out = m_lvl && (!mod_en || carrier_on(el, duty));
      e_irq = irq_sel ? (!m_busy || !tx_en) : (sz <= 8);
      if (tick && tx_en) begin
        if (rem > 1) begin
          rem--; el++;
        end else if (sz > 0) begin
          ent = q.pop_front();
          rem = int'(ent[15:0]) * 16;
          m_lvl = ent[16]; m_busy = 1; el = 0;
        end else begin
          rem = 0; m_lvl = 0; m_busy = 0;
        end
      end
      if (wr_valid && sz < 16) q.push_back(wr_data);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R3 R4 R5 R7 R8", "tx_out", tx_out, e_out);
      check("R6 R10", "busy", busy, m_busy);
      check("R2", "fifo_count", fifo_count, q.size());
      check("R2", "fifo_full", fifo_full, q.size() == 16);
      check("R9", "irq", irq, e_irq);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(posedge clk); chk_on = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "reset tx_out", tx_out, 0);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset count", fifo_count, 0);
    check("R1", "reset irq", irq, 0);
    rst = 1'b0;

    // R2: overfill with transmission disabled
    for (int i = 0; i < 18; i++) begin
      wr_valid = 1'b1; wr_data = {i[0], 16'(i % 3)};
      cyc(1);
    end
    wr_valid = 1'b0;
    cyc(2);
    check("R2", "count after overfill", fifo_count, 16);

    // R3 R5 R6: plain level output, tick every cycle
    tx_en = 1'b1; tick = 1'b1;
    cyc(800);
    check("R6", "idle busy after drain", busy, 0);
    check("R6", "idle output after drain", tx_out, 0);

    // R7 R8: modulated marks with reserved duty, then a low duty
    mod_en = 1'b1;
    for (int d = 0; d < 2; d++) begin
      duty = d ? 4'd0 : 4'd15;
      for (int i = 0; i < 3; i++) begin
        wr_valid = 1'b1; wr_data = {1'b1, 16'd2}; cyc(1);
        wr_valid = 1'b1; wr_data = {1'b0, 16'd1}; cyc(1);
      end
      wr_valid = 1'b0;
      cyc(400);
    end

    // Random traffic; R4 via tx_en drops, R9 via irq_sel changes
    for (int c = 0; c < 30000; c++) begin
      if (c % 500 == 0) begin
        mod_en  = $urandom_range(0, 1);
        duty    = 4'($urandom_range(0, 15));
        irq_sel = $urandom_range(0, 1);
      end
      tick     = ($urandom_range(0, 3) != 0);
      tx_en    = ($urandom_range(0, 31) != 0);
      wr_valid = ($urandom_range(0, 7) == 0) || (c % 4000 < 40);
      wr_data  = {1'($urandom_range(0, 1)), 16'($urandom_range(0, 3))};
      cyc(1);
    end
    wr_valid = 1'b0; tx_en = 1'b1; tick = 1'b1;
    cyc(1500);
    check("R6", "final busy", busy, 0);
    check("R6", "final output", tx_out, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule